// File: doc/BRIEF.md
# Peripheral Register Window Bus Bridge

This block stands between a processor's bus-cycle sequencer and an internal 16-bit peripheral register bus. It takes one memory or I/O request at a time and checks whether the address falls in a 256-byte register window. The window sits in the memory or I/O space chosen by a parameter and starts at a parameterized page base. A request that hits the window goes to the internal registers as one whole 16-bit word, and the bridge paces it with its own ready. Addresses in the timer sub-range get one wait state. Every other window address completes with no wait state.

Every request, whether it hits the window or not, is also driven onto the external bus pins. For window hits the external ready and the external read data are ignored. For requests outside the window the external device sets the pace, and its read data is passed back unchanged. A parameter selects a 16-bit or an 8-bit external bus. On the 8-bit bus a word access to the window is mirrored as two byte cycles: the even byte goes first and the odd byte second, both on the low data lane. The internal register is still accessed only once, as a full word.

The request side is a valid/ready channel. `req_ready` is high only while the bridge is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The requester must be ready to take the data in that cycle.

Top module: `pwin_bridge`

## Requirements
- R1: A request hits the window exactly when `req_io` equals parameter WIN_IO and `req_addr[AW-1:8]` equals `WIN_BASE[AW-1:8]`. Every other request, including one in the wrong space, is handled as an external access.
- R2: Every accepted request drives bus cycles on the external pins. `ext_cyc` is high in every cycle from acceptance to completion. During those cycles `ext_addr`, `ext_io`, `ext_write` and `ext_wdata` carry the access.
- R3: For a window hit, `ext_ready` has no effect on completion timing, `ext_rdata` is discarded, and `rsp_rdata` takes the value from the internal register bus.
- R4: A window read whose offset the peripherals do not claim (`reg_hit` low) still completes on internal timing and returns 0x0000.
- R5: A window offset in [TMR_LO, TMR_HI] gets TMR_WAIT wait states (default 1). On the 16-bit bus its response comes in the 2nd cycle after acceptance.
- R6: Any other window offset gets zero wait states. On the 16-bit bus its response comes in the 1st cycle after acceptance.
- R7: With NARROW=1 a window access makes two byte cycles, each one base cycle plus its wait states. The first cycle has `ext_addr[0]`=0 and `ext_wdata[7:0]` = write data bits 7:0. The second has `ext_addr[0]`=1 and bits 15:8. The response comes in cycle 2*(1+waits).
- R8: An external access is a single bus cycle that completes in the first cycle where `ext_ready` is high. `rsp_rdata` then equals `ext_rdata`.
- R9: `req_ready` is low from acceptance through completion and high again the cycle after. `rsp_valid` is high for exactly one cycle per request.
- R10: A window write pulses `reg_sel` and `reg_we` for one cycle, in the completion cycle. `reg_wdata` carries the full word and `reg_offset` the word-aligned offset. A write to an unclaimed offset changes no register.
- R11: After reset `req_ready` is high, and `rsp_valid`, `ext_cyc`, `reg_sel` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request accepted on this edge |
| req_addr | input | AW | Request byte address (word aligned for window words) |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, valid with rsp_valid |
| reg_sel | output | 1 | Internal register access strobe |
| reg_we | output | 1 | Internal register write strobe |
| reg_offset | output | 8 | Word-aligned window offset |
| reg_wdata | output | 16 | Internal write word |
| reg_rdata | input | 16 | Internal read word for reg_offset |
| reg_hit | input | 1 | Peripherals claim reg_offset |
| ext_cyc | output | 1 | External bus cycle in progress |
| ext_addr | output | AW | External address |
| ext_io | output | 1 | External space select |
| ext_write | output | 1 | External write |
| ext_wdata | output | 16 | External write data (low lane in byte cycles) |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External ready |

## Verification
A window response is due a fixed number of cycles after acceptance: 1+waits on the 16-bit bus and 2*(1+waits) on the 8-bit bus. An external response is due in the cycle after the modelled device has counted its programmed delay. Wide and narrow instances take the same stimulus. The bench counts cycles at falling edges from the accepting edge and records the cycle in which each `rsp_valid` appears, so latency is compared as an exact number and not found by waiting. Read data, byte-lane address and lane data are sampled in the first bus cycle and in the completion cycle.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic {
    PW_IDLE = 1'b0,
    PW_BUSY = 1'b1
  } pw_state_e;

  function automatic int unsigned pw_beats(input bit narrow, input bit hit);
    return (narrow && hit) ? 2 : 1;
  endfunction
endpackage

// File: rtl/pwin_decode.sv
module pwin_decode #(
  parameter int          AW       = 20,
  parameter logic [AW-1:0] WIN_BASE = 20'h0FF00,
  parameter bit          WIN_IO   = 1'b1,
  parameter logic [7:0]  TMR_LO   = 8'h30,
  parameter logic [7:0]  TMR_HI   = 8'h5E
) (
  input  logic [AW-1:0] addr,
  input  logic          io,
  output logic          hit,
  output logic          tmr
);
  localparam int PW = AW - 8;
  localparam logic [PW-1:0] PAGE = WIN_BASE[AW-1:8];

  logic page_eq;
  logic in_tmr;

  always_comb begin
    page_eq = (addr[AW-1:8] == PAGE);
    hit     = page_eq && (io == WIN_IO);
    in_tmr  = (addr[7:0] >= TMR_LO) && (addr[7:0] <= TMR_HI);
    tmr     = hit && in_tmr;
  end
endmodule

// File: rtl/pwin_seq.sv
module pwin_seq
  import pwin_pkg::*;
#(
  parameter bit NARROW   = 1'b0,
  parameter int TMR_WAIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  input  logic tmr,
  input  logic ext_ready,
  output logic busy,
  output logic hit_q,
  output logic beat,
  output logic done
);
  localparam int WCW = (TMR_WAIT < 1) ? 1 : $clog2(TMR_WAIT + 1);
  localparam int NB  = pw_beats(NARROW, 1'b1);

  pw_state_e      st_q;
  logic           tmr_q;
  logic           beat_q;
  logic [WCW-1:0] wcnt_q;
  logic [WCW-1:0] wait_lim;
  logic           last_beat;
  logic           beat_end;
  logic [7:0]     elapsed_q;

  always_comb begin
    wait_lim  = (hit_q && tmr_q) ? WCW'(TMR_WAIT) : '0;
    last_beat = (NARROW && hit_q) ? beat_q : 1'b1;
    if (st_q != PW_BUSY)
      beat_end = 1'b0;
    else if (hit_q)
      beat_end = (wcnt_q == wait_lim);
    else
      beat_end = ext_ready;
    done = beat_end && last_beat;
    busy = (st_q == PW_BUSY);
    beat = beat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PW_IDLE;
      hit_q     <= 1'b0;
      tmr_q     <= 1'b0;
      beat_q    <= 1'b0;
      wcnt_q    <= '0;
      elapsed_q <= '0;
    end else if (st_q == PW_IDLE) begin
      if (start) begin
        st_q      <= PW_BUSY;
        hit_q     <= hit;
        tmr_q     <= tmr;
        beat_q    <= 1'b0;
        wcnt_q    <= '0;
        elapsed_q <= '0;
      end
    end else begin
      if (elapsed_q != 8'hFF) elapsed_q <= elapsed_q + 8'd1;
      if (done) begin
        st_q <= PW_IDLE;
      end else if (beat_end) begin
        beat_q <= 1'b1;
        wcnt_q <= '0;
      end else if (hit_q) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // R5 R6 R7: a window completion lands exactly after beats*(1+waits) bus cycles
  a_r5_window_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit_q) |-> (elapsed_q == 8'(NB * (int'(wait_lim) + 1) - 1)
                         || (!NARROW && elapsed_q == 8'(int'(wait_lim)))));

  // R8: external completion only on external ready
  a_r8_ext_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit_q) |-> ext_ready);

  // R9: after completion the sequencer is idle
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath #(
  parameter int AW     = 20,
  parameter bit NARROW = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [15:0]   req_wdata,
  input  logic          busy,
  input  logic          hit_q,
  input  logic          beat,
  input  logic          done,
  input  logic [15:0]   reg_rdata,
  input  logic          reg_hit,
  input  logic [15:0]   ext_rdata,
  output logic [15:0]   rsp_rdata,
  output logic          reg_sel,
  output logic          reg_we,
  output logic [7:0]    reg_offset,
  output logic [15:0]   reg_wdata,
  output logic          ext_cyc,
  output logic [AW-1:0] ext_addr,
  output logic          ext_io,
  output logic          ext_write,
  output logic [15:0]   ext_wdata
);
  logic [AW-1:0] addr_q;
  logic          io_q;
  logic          wr_q;
  logic [15:0]   wdata_q;
  logic          split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      io_q    <= req_io;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    split      = NARROW && hit_q;
    ext_cyc    = busy;
    ext_io     = io_q;
    ext_write  = wr_q;
    ext_addr   = {addr_q[AW-1:1], split ? beat : addr_q[0]};
    reg_offset = {addr_q[7:1], 1'b0};
    reg_wdata  = wdata_q;
    reg_sel    = done && hit_q;
    reg_we     = done && hit_q && wr_q;
    if (hit_q)
      rsp_rdata = reg_hit ? reg_rdata : 16'h0000;
    else
      rsp_rdata = ext_rdata;
  end

  generate
    if (NARROW) begin : g_byte_lane
      always_comb begin
        if (hit_q)
          ext_wdata = {8'h00, beat ? wdata_q[15:8] : wdata_q[7:0]};
        else
          ext_wdata = wdata_q;
      end
    end else begin : g_word_lane
      always_comb ext_wdata = wdata_q;
    end
  endgenerate

  // R4: an unclaimed window read returns zero
  a_r4_unclaimed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_hit) |-> (rsp_rdata == 16'h0000));

  // R10: register write strobe lasts one cycle
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R2: the external address is held steady within a bus cycle
  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cyc && $past(ext_cyc) && !$past(done) && $stable(beat)) |-> $stable(ext_addr));
endmodule

// File: rtl/pwin_bridge.sv
module pwin_bridge #(
  parameter int            AW       = 20,
  parameter logic [AW-1:0] WIN_BASE = 20'h0FF00,
  parameter bit            WIN_IO   = 1'b1,
  parameter logic [7:0]    TMR_LO   = 8'h30,
  parameter logic [7:0]    TMR_HI   = 8'h5E,
  parameter int            TMR_WAIT = 1,
  parameter bit            NARROW   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          reg_sel,
  output logic          reg_we,
  output logic [7:0]    reg_offset,
  output logic [15:0]   reg_wdata,
  input  logic [15:0]   reg_rdata,
  input  logic          reg_hit,
  output logic          ext_cyc,
  output logic [AW-1:0] ext_addr,
  output logic          ext_io,
  output logic          ext_write,
  output logic [15:0]   ext_wdata,
  input  logic [15:0]   ext_rdata,
  input  logic          ext_ready
);
  logic dec_hit, dec_tmr;
  logic busy, hit_q, beat, done, start;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;
  assign rsp_valid = done;

  pwin_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .WIN_IO(WIN_IO),
    .TMR_LO(TMR_LO), .TMR_HI(TMR_HI)
  ) dec_i (
    .addr(req_addr), .io(req_io), .hit(dec_hit), .tmr(dec_tmr)
  );

  pwin_seq #(.NARROW(NARROW), .TMR_WAIT(TMR_WAIT)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(dec_hit), .tmr(dec_tmr),
    .ext_ready(ext_ready), .busy(busy), .hit_q(hit_q), .beat(beat), .done(done)
  );

  pwin_datapath #(.AW(AW), .NARROW(NARROW)) dp_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_addr(req_addr), .req_io(req_io), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .hit_q(hit_q), .beat(beat), .done(done),
    .reg_rdata(reg_rdata), .reg_hit(reg_hit), .ext_rdata(ext_rdata),
    .rsp_rdata(rsp_rdata), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .ext_cyc(ext_cyc), .ext_addr(ext_addr), .ext_io(ext_io),
    .ext_write(ext_write), .ext_wdata(ext_wdata)
  );

  // R2: every cycle of an access drives the external bus
  a_r2_mirror_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> ext_cyc);

  // R9: a taken request closes the request channel on the next cycle
  a_r9_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: register strobes only in a response cycle
  a_r10_sel_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rsp_valid);
endmodule

// File: tb/pwin_bridge_tb.sv
module pwin_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam logic [AW-1:0] BASE = 20'h0FF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_io = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_wdata = '0;
  logic [3:0]    ext_delay = 4'd15;

  logic          rdy_w, rdy_n, rv_w, rv_n, sel_w, sel_n, we_w, we_n;
  logic          cyc_w, cyc_n, io_w, io_n, ewr_w, ewr_n, rh_w, rh_n, er_w, er_n;
  logic [15:0]   rd_w, rd_n, rwd_w, rwd_n, rrd_w, rrd_n, ewd_w, ewd_n, erd_w, erd_n;
  logic [7:0]    off_w, off_n;
  logic [AW-1:0] ea_w, ea_n;
  logic [15:0]   mem_w [128];
  logic [15:0]   mem_n [128];
  logic [15:0]   shadow [128];
  logic [3:0]    cnt_w, cnt_n;

  pwin_bridge #(.NARROW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w),
    .req_addr(req_addr), .req_io(req_io), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rv_w), .rsp_rdata(rd_w), .reg_sel(sel_w), .reg_we(we_w),
    .reg_offset(off_w), .reg_wdata(rwd_w), .reg_rdata(rrd_w), .reg_hit(rh_w),
    .ext_cyc(cyc_w), .ext_addr(ea_w), .ext_io(io_w), .ext_write(ewr_w),
    .ext_wdata(ewd_w), .ext_rdata(erd_w), .ext_ready(er_w));

  pwin_bridge #(.NARROW(1'b1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_n),
    .req_addr(req_addr), .req_io(req_io), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rv_n), .rsp_rdata(rd_n), .reg_sel(sel_n), .reg_we(we_n),
    .reg_offset(off_n), .reg_wdata(rwd_n), .reg_rdata(rrd_n), .reg_hit(rh_n),
    .ext_cyc(cyc_n), .ext_addr(ea_n), .ext_io(io_n), .ext_write(ewr_n),
    .ext_wdata(ewd_n), .ext_rdata(erd_n), .ext_ready(er_n));

  // peripheral models: offsets below 0xA0 are claimed
  assign rh_w  = off_w < 8'hA0;
  assign rh_n  = off_n < 8'hA0;
  assign rrd_w = mem_w[off_w[7:1]];
  assign rrd_n = mem_n[off_n[7:1]];
  always_ff @(posedge clk) begin
    if (we_w && rh_w) mem_w[off_w[7:1]] <= rwd_w;
    if (we_n && rh_n) mem_n[off_n[7:1]] <= rwd_n;
  end

  // external device models
  assign erd_w = 16'hC3C3 ^ ea_w[15:0];
  assign erd_n = 16'hC3C3 ^ ea_n[15:0];
  assign er_w  = cnt_w >= ext_delay;
  assign er_n  = cnt_n >= ext_delay;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_w <= '0; cnt_n <= '0;
    end else begin
      cnt_w <= (cyc_w && !rv_w) ? ((cnt_w == 4'hF) ? cnt_w : cnt_w + 4'd1) : 4'd0;
      cnt_n <= (cyc_n && !rv_n) ? ((cnt_n == 4'hF) ? cnt_n : cnt_n + 4'd1) : 4'd0;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [AW-1:0] a, input bit io);
    return io && (a[AW-1:8] == BASE[AW-1:8]);
  endfunction

  // one access on both instances; delay = external ready delay for outside accesses
  task automatic access(input logic [AW-1:0] a, input bit io, input bit wr,
                        input logic [15:0] wd, input logic [3:0] dly);
    int lat_w = 0, lat_n = 0, pulses_w = 0, pulses_n = 0, cycs_n = 0;
    logic [15:0] dw = '0, dn = '0, first_wd_n = '0, last_wd_n = '0;
    logic [AW-1:0] first_a_n = '0, last_a_n = '0, a_w = '0;
    bit hit, tm;
    int w, exp_w, exp_n;
    logic [15:0] exp_d;
    hit = in_win(a, io);
    tm  = hit && (a[7:0] >= 8'h30) && (a[7:0] <= 8'h5E);
    w   = tm ? 1 : 0;
    exp_w = hit ? 1 + w : dly + 1;
    exp_n = hit ? 2 * (1 + w) : dly + 1;
    if (!hit) exp_d = 16'hC3C3 ^ a[15:0];
    else exp_d = (a[7:0] < 8'hA0) ? shadow[a[7:1]] : 16'h0000;

    @(negedge clk);
    ext_delay = hit ? 4'd0 : dly;  // window: ready high at once, must be ignored
    if (hit) ext_delay = (a[1]) ? 4'd15 : 4'd0;
    req_valid = 1'b1; req_addr = a; req_io = io; req_write = wr; req_wdata = wd;
    @(posedge clk);
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (c == 1) begin
        req_valid = 1'b0;
        chk(!rdy_w && !rdy_n, "R9 ready low while busy", {rdy_w, rdy_n}, 0);
        first_a_n = ea_n; first_wd_n = ewd_n;
      end
      if (cyc_n) cycs_n++;
      if (rv_w) begin pulses_w++; lat_w = c; dw = rd_w; a_w = ea_w; end
      if (rv_n) begin pulses_n++; lat_n = c; dn = rd_n; last_a_n = ea_n; last_wd_n = ewd_n; end
    end
    if (hit && wr && a[7:0] < 8'hA0) shadow[a[7:1]] = wd;

    chk(pulses_w == 1 && pulses_n == 1, "R9 one response pulse", pulses_w * 16 + pulses_n, 17);
    if (hit) begin
      chk(lat_w == exp_w, tm ? "R5 timer latency wide" : "R6 zero-wait latency wide", lat_w, exp_w);
      chk(lat_n == exp_n, "R7 narrow split latency", lat_n, exp_n);
      chk(cycs_n == exp_n, "R2 narrow mirrored cycles", cycs_n, exp_n);
      chk(first_a_n == {a[AW-1:1], 1'b0} && last_a_n == {a[AW-1:1], 1'b1},
          "R7 byte addresses", int'(last_a_n), int'({a[AW-1:1], 1'b1}));
      chk(a_w == a, "R2 wide mirrored address", int'(a_w), int'(a));
      if (wr) begin
        chk(first_wd_n[7:0] == wd[7:0] && last_wd_n[7:0] == wd[15:8],
            "R7 byte lane data", {first_wd_n[7:0], last_wd_n[7:0]}, {wd[7:0], wd[15:8]});
      end else begin
        chk(dw == exp_d, (a[7:0] < 8'hA0) ? "R3 window read wide" : "R4 unclaimed zero wide", dw, exp_d);
        chk(dn == exp_d, (a[7:0] < 8'hA0) ? "R3 window read narrow" : "R4 unclaimed zero narrow", dn, exp_d);
      end
    end else begin
      chk(lat_w == exp_w && lat_n == exp_n, "R8 external latency", lat_w * 16 + lat_n, exp_w * 17);
      chk(cycs_n == 1 * exp_n, "R8 single external cycle", cycs_n, exp_n);
      if (!wr) chk(dw == exp_d && dn == exp_d, "R1 R8 external data passthrough", dw, exp_d);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem_w[i] = 16'h5A00 | 16'(i);
      mem_n[i] = 16'h5A00 | 16'(i);
      shadow[i] = 16'h5A00 | 16'(i);
    end
    repeat (3) @(negedge clk);
    chk(rdy_w && rdy_n, "R11 reset ready", {rdy_w, rdy_n}, 3);
    chk(!rv_w && !rv_n && !cyc_w && !cyc_n && !sel_w && !we_n, "R11 reset quiet",
        {rv_w, rv_n, cyc_w, cyc_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R6 R7: full read sweep of every window word
    for (int i = 0; i < 128; i++) access(BASE | AW'(2 * i), 1'b1, 1'b0, 16'h0, 4'd0);

    // R10: writes at sub-range edges and to an unclaimed offset, then read back
    access(BASE | 20'h00, 1'b1, 1'b1, 16'h1234, 4'd0);
    access(BASE | 20'h30, 1'b1, 1'b1, 16'hBEEF, 4'd0);
    access(BASE | 20'h5E, 1'b1, 1'b1, 16'hA55A, 4'd0);
    access(BASE | 20'h60, 1'b1, 1'b1, 16'h0F0F, 4'd0);
    access(BASE | 20'hA0, 1'b1, 1'b1, 16'h7777, 4'd0);
    access(BASE | 20'h00, 1'b1, 1'b0, 16'h0, 4'd0);
    access(BASE | 20'h30, 1'b1, 1'b0, 16'h0, 4'd0);
    access(BASE | 20'h5E, 1'b1, 1'b0, 16'h0, 4'd0);
    access(BASE | 20'h60, 1'b1, 1'b0, 16'h0, 4'd0);
    access(BASE | 20'hA0, 1'b1, 1'b0, 16'h0, 4'd0);
    chk(mem_w[8'hA0 >> 1] == (16'h5A00 | 16'h50), "R10 unclaimed write no effect",
        mem_w[8'hA0 >> 1], 16'h5A50);

    // R1 R8: outside accesses with various external delays
    for (int d = 0; d < 4; d++) access(20'h0FE10 + AW'(2 * d), 1'b1, 1'b0, 16'h0, 4'(d));
    access(20'h0FF10, 1'b0, 1'b0, 16'h0, 4'd2);   // R1 wrong space
    access(20'h10000, 1'b1, 1'b0, 16'h0, 4'd1);   // R1 next page
    access(20'h0FEFE, 1'b1, 1'b1, 16'h4321, 4'd3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule